// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits on the host side of a single-lane SPI link to a large serial NOR flash. A client hands it one request at a time: an opcode selector, a byte address and a length. The block turns that request into the chip-select frames the flash expects and reports completion with a one-cycle `done` pulse. The client supplies program data through a show-ahead byte port that the block pops with `wd_req`. Read bytes come back on `rdata` with a `rdata_valid` strobe.

Any request that modifies the array is wrapped in three frames. The first is a write-enable frame. The second is the command itself. The third is a status frame that keeps chip select low and keeps clocking status bytes until the busy bit clears. The block also remembers whether the flash has been switched to 4-byte addressing and sizes the address field to match. Program requests that would wrap within a page, and requests with bad lengths or unknown selectors, are refused without touching the bus.

Top module: `spi_nor_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `req_ready` is 1, `done` is 0 and `addr4` is 0 (3-byte addressing).
- R2: The link runs in SPI mode 0. `sclk` stays low whenever `cs_n` is high. Each byte goes out MSB first on `mosi`, which changes while `sclk` is low. `miso` is sampled on the rising edge of `sclk`.
- R3: Every program or erase request (`req_op` 3 to 7) starts with a frame holding only byte 06h.
- R4: A program request (`req_op`=3) sends 02h, then the address, then `req_len` data bytes. Each data byte is taken from `wdata` in the cycle `wd_req` is high, one pop per byte.
- R5: Erase requests send an opcode and then the address: `req_op`=4 sends 20h (4 KB), 5 sends 52h (32 KB), 6 sends D8h (64 KB). `req_op`=7 sends C7h with no address.
- R6: `req_op`=0 sends 03h with an address as wide as the current mode. `req_op`=1 sends 13h with 4 address bytes in either mode. Both return `req_len` bytes in order on `rdata`/`rdata_valid`.
- R7: `req_op`=2 sends 0Bh, then the address, then one byte (8 clocks) of dummy, then returns `req_len` bytes.
- R8: `req_op`=9 sends B7h and sets `addr4` to 1. `req_op`=10 sends E9h and clears it. The address fields of opcodes 03h, 0Bh, 02h, 20h, 52h and D8h are 4 bytes while `addr4` is 1 and 3 bytes otherwise. The address is sent most significant byte first.
- R9: After the command frame of a program or erase, a frame sends 05h and then clocks status bytes until a byte with bit 0 equal to 0 is received. Only then does `done` pulse.
- R10: A request is refused if any of these hold: a program whose low address byte plus `req_len` exceeds 256; a read, fast read or program with `req_len` of 0 or above 256; or `req_op` above 10. A refused request gives `done` and `err` high in the cycle after acceptance, and `cs_n` never falls.
- R11: Between consecutive frames, `cs_n` stays high for at least two system clocks.
- R12: `req_op`=8 sends 05h and returns exactly one status byte on `rdata`.
- R13: `done` is a single-cycle pulse. `err` is 0 on every accepted request that is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_op | input | 4 | Request selector (encoding in R4 to R12) |
| req_addr | input | 32 | Byte address |
| req_len | input | 9 | Byte count for read, fast read and program |
| wdata | input | 8 | Show-ahead program data byte |
| wd_req | output | 1 | Pop of `wdata` |
| rdata | output | 8 | Returned byte |
| rdata_valid | output | 1 | `rdata` strobe |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request refused, valid with `done` |
| addr4 | output | 1 | 4-byte address mode in effect |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bench builds the sequencer with a divide of 2 and the minimum gap of 2. With those values, a full 256-byte program frame costs only a few thousand cycles. That makes it practical to sweep program offsets against lengths on both sides of the page edge, including the exact-fit and one-over cases. The bench also contains a small flash model that tracks its own address mode and busy countdown. This lets it check every opcode in both address widths, and the status poll running over several busy bytes.

// File: rtl/spi_nor_seq.sv
module spi_nor_seq #(
  parameter int DIV = 4,
  parameter int GAP = 2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_op,
  input  logic [31:0] req_addr,
  input  logic [8:0]  req_len,
  input  logic [7:0]  wdata,
  output logic        wd_req,
  output logic [7:0]  rdata,
  output logic        rdata_valid,
  output logic        done,
  output logic        err,
  output logic        addr4,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [3:0] OP_RD = 4'd0, OP_RD4 = 4'd1, OP_FAST = 4'd2, OP_PROG = 4'd3,
    OP_SEC = 4'd4, OP_B32 = 4'd5, OP_B64 = 4'd6, OP_CHIP = 4'd7, OP_STAT = 4'd8,
    OP_EN4 = 4'd9, OP_EX4 = 4'd10;
  localparam logic [1:0] F_WEN = 2'd0, F_CMD = 2'd1, F_POLL = 2'd2, F_END = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_FIN} st_t;

  function automatic logic [7:0] opc(input logic [3:0] o);
    case (o)
      OP_RD:   opc = 8'h03;
      OP_RD4:  opc = 8'h13;
      OP_FAST: opc = 8'h0B;
      OP_PROG: opc = 8'h02;
      OP_SEC:  opc = 8'h20;
      OP_B32:  opc = 8'h52;
      OP_B64:  opc = 8'hD8;
      OP_CHIP: opc = 8'hC7;
      OP_STAT: opc = 8'h05;
      OP_EN4:  opc = 8'hB7;
      OP_EX4:  opc = 8'hE9;
      default: opc = 8'h00;
    endcase
  endfunction

  st_t         st;
  logic [1:0]  frm;
  logic [3:0]  op_q;
  logic [31:0] addr_q;
  logic [8:0]  len_q;
  logic [2:0]  alen_q, bit_q;
  logic [9:0]  idx;
  logic [DW-1:0] div_q;
  logic [GW-1:0] gap_q;
  logic        sclk_q, a4_q, err_q, rdv_q;
  logic [7:0]  tx_sr, rx_sr, rdata_q;

  logic        tick, byte_done, gap_end, fend, load, is_mod, is_rd, bad, take;
  logic [9:0]  hdr, ndata, last, ld_idx;
  logic [7:0]  ld_byte;
  logic [31:0] a_sh;
  logic [1:0]  nfrm;

  assign is_mod = (op_q >= OP_PROG) && (op_q <= OP_CHIP);
  assign is_rd  = (op_q <= OP_FAST) || (op_q == OP_STAT);
  assign hdr    = 10'd1 + {7'd0, alen_q} + ((op_q == OP_FAST) ? 10'd1 : 10'd0);
  assign ndata  = (op_q <= OP_PROG) ? {1'b0, len_q} : (op_q == OP_STAT) ? 10'd1 : 10'd0;
  assign last   = hdr + ndata - 10'd1;
  assign tick      = (st == S_XFER) && (div_q == DW'(DIV - 1));
  assign byte_done = tick && sclk_q && (bit_q == 3'd7);
  assign gap_end   = (st == S_GAP) && (gap_q == GW'(GAP - 1));
  assign fend = (frm == F_WEN) || ((frm == F_CMD) && (idx == last)) ||
                ((frm == F_POLL) && (idx != 10'd0) && !rx_sr[0]);
  assign load = (gap_end && (frm != F_END)) || (byte_done && !fend);
  assign ld_idx = (st == S_GAP) ? 10'd0 : idx + 10'd1;
  assign a_sh = addr_q >> {alen_q - ld_idx[2:0], 3'b000};
  assign nfrm = (frm == F_WEN) ? F_CMD : ((frm == F_CMD) && is_mod) ? F_POLL : F_END;
  assign take = req_valid && (st == S_IDLE);
  assign bad = (req_op > OP_EX4) ||
               ((req_op <= OP_PROG) && ((req_len == 9'd0) || (req_len > 9'd256))) ||
               ((req_op == OP_PROG) && (({2'b0, req_addr[7:0]} + {1'b0, req_len}) > 10'd256));

  always_comb begin
    case (frm)
      F_WEN:   ld_byte = 8'h06;
      F_POLL:  ld_byte = (ld_idx == 10'd0) ? 8'h05 : 8'h00;
      default: begin
        if (ld_idx == 10'd0)                     ld_byte = opc(op_q);
        else if (ld_idx <= {7'd0, alen_q})       ld_byte = a_sh[7:0];
        else if (ld_idx >= hdr && op_q == OP_PROG) ld_byte = wdata;
        else                                     ld_byte = 8'h00;
      end
    endcase
  end

  assign wd_req = load && (frm == F_CMD) && (op_q == OP_PROG) && (ld_idx >= hdr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; frm <= F_END; op_q <= '0; addr_q <= '0; len_q <= '0;
      alen_q <= '0; bit_q <= '0; idx <= '0; div_q <= '0; gap_q <= '0;
      sclk_q <= 1'b0; a4_q <= 1'b0; err_q <= 1'b0; rdv_q <= 1'b0;
      tx_sr <= '0; rx_sr <= '0; rdata_q <= '0;
    end else begin
      rdv_q <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          op_q <= req_op; addr_q <= req_addr; len_q <= req_len;
          err_q <= bad; gap_q <= '0;
          case (req_op)
            OP_RD, OP_FAST, OP_PROG, OP_SEC, OP_B32, OP_B64: alen_q <= a4_q ? 3'd4 : 3'd3;
            OP_RD4:  alen_q <= 3'd4;
            default: alen_q <= 3'd0;
          endcase
          frm <= (req_op >= OP_PROG && req_op <= OP_CHIP) ? F_WEN : F_CMD;
          st  <= bad ? S_FIN : S_GAP;
        end
        S_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_end) begin
            if (frm == F_END) st <= S_FIN;
            else begin
              st <= S_XFER; idx <= '0; bit_q <= '0; div_q <= '0;
              sclk_q <= 1'b0; tx_sr <= ld_byte;
            end
          end
        end
        S_XFER: begin
          if (!tick) div_q <= div_q + 1'b1;
          else begin
            div_q <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_sr  <= {rx_sr[6:0], miso};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q != 3'd7) begin
                bit_q <= bit_q + 1'b1;
                tx_sr <= {tx_sr[6:0], 1'b0};
              end else begin
                bit_q <= '0;
                if (frm == F_CMD && is_rd && idx >= hdr) begin
                  rdv_q <= 1'b1; rdata_q <= rx_sr;
                end
                if (fend) begin
                  st <= S_GAP; gap_q <= '0; frm <= nfrm;
                  if (frm == F_CMD && op_q == OP_EN4) a4_q <= 1'b1;
                  if (frm == F_CMD && op_q == OP_EX4) a4_q <= 1'b0;
                end else begin
                  idx <= ld_idx; tx_sr <= ld_byte;
                end
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign done        = (st == S_FIN);
  assign err         = (st == S_FIN) && err_q;
  assign addr4       = a4_q;
  assign cs_n        = (st != S_XFER);
  assign sclk        = sclk_q;
  assign mosi        = (st == S_XFER) ? tx_sr[7] : 1'b0;
  assign rdata       = rdata_q;
  assign rdata_valid = rdv_q;
endmodule

// File: rtl/spi_nor_seq_chk.sv
module spi_nor_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] req_op,
  input logic [7:0] req_lo,
  input logic [8:0] req_len,
  input logic       done,
  input logic       err,
  input logic       addr4,
  input logic       cs_n,
  input logic       sclk,
  input logic       wd_req
);
  logic refuse;
  assign refuse = (req_op > 4'd10) ||
                  ((req_op <= 4'd3) && ((req_len == 9'd0) || (req_len > 9'd256))) ||
                  ((req_op == 4'd3) && (({2'b0, req_lo} + {1'b0, req_len}) > 10'd256));

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);
  p_sclk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_pop_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_req |-> !cs_n);
  p_mode_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr4) |-> cs_n);
  p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && refuse) |=> (done && err && cs_n));
  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind spi_nor_seq spi_nor_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_lo(req_addr[7:0]), .req_len(req_len), .done(done),
  .err(err), .addr4(addr4), .cs_n(cs_n), .sclk(sclk), .wd_req(wd_req)
);

// File: tb/spi_nor_seq_tb.sv
`timescale 1ns/1ps
module spi_nor_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [31:0] req_addr = '0;
  logic [8:0] req_len = '0;
  logic [7:0] wdata, rdata;
  logic req_ready, wd_req, rdata_valid, done, err, addr4, cs_n, sclk, mosi, miso;

  always #2 clk = ~clk;

  spi_nor_seq #(.DIV(2), .GAP(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .wdata(wdata),
    .wd_req(wd_req), .rdata(rdata), .rdata_valid(rdata_valid), .done(done),
    .err(err), .addr4(addr4), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
  endfunction

  // program data source (show-ahead)
  logic [7:0] wbuf [0:255];
  int wptr = 0;
  assign wdata = wbuf[wptr[7:0]];
  always @(posedge clk) if (wd_req) wptr <= wptr + 1;

  // read capture
  logic [7:0] rbuf [0:271];
  int rcnt = 0;
  always @(negedge clk) if (rdata_valid && rcnt < 272) begin rbuf[rcnt] = rdata; rcnt++; end

  // flash model
  logic [7:0] fb [0:7][0:271];
  int flen [0:7];
  int nf = 0, bitc = 0, bytec = 0, busy_left = 0;
  bit m4 = 0;
  logic [7:0] sin = '0, osr = '0, nout = '0;
  assign miso = osr[7];

  task automatic model_byte(input int b);
    logic [7:0] op;
    int al, h, n;
    logic [31:0] a;
    op = fb[nf][0];
    n = b + 1;
    if (b == 0) begin
      if (op == 8'hB7) m4 = 1;
      if (op == 8'hE9) m4 = 0;
      if (op == 8'h02 || op == 8'h20 || op == 8'h52 || op == 8'hD8 || op == 8'hC7)
        busy_left = 3;
    end
    nout = 8'h00;
    if (op == 8'h05) begin
      nout = (busy_left > 0) ? 8'hA5 : 8'hA4;
      if (busy_left > 0) busy_left--;
    end else if (op == 8'h03 || op == 8'h13 || op == 8'h0B) begin
      al = (op == 8'h13 || m4) ? 4 : 3;
      h = 1 + al + ((op == 8'h0B) ? 1 : 0);
      if (n >= h) begin
        a = '0;
        for (int k = 1; k <= al; k++) a = {a[23:0], fb[nf][k]};
        nout = pat(a + 32'(n - h));
      end
    end
  endtask

  always @(negedge cs_n) begin bitc = 0; bytec = 0; end
  always @(posedge cs_n) if (bytec > 0 && nf < 8) begin flen[nf] = bytec; nf++; bytec = 0; end
  always @(posedge sclk) if (!cs_n && nf < 8) begin
    sin = {sin[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (bytec < 272) fb[nf][bytec] = sin;
      model_byte(bytec);
      bytec++;
    end
  end
  always @(negedge sclk) if (!cs_n) begin
    if (bitc == 0) osr = nout; else osr = {osr[6:0], 1'b0};
  end

  // gap and mode-0 monitors
  int hi_run = 0, min_gap = 1000, idle_clk = 0;
  bit seen = 0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n && sclk) idle_clk++;
    if (cs_n) hi_run++;
    else begin
      if (seen && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      if (hi_run > 0) seen = 1;
      hi_run = 0;
    end
  end

  // expected frame
  logic [7:0] ex [0:271];
  int exn = 0;

  task automatic check_frame(input int f, input string tag);
    int bad_at;
    bad_at = -1;
    if (flen[f] != exn) begin
      chk(0, {tag, " frame length"}, flen[f], exn);
    end else begin
      for (int k = 0; k < exn; k++) if (bad_at < 0 && fb[f][k] != ex[k]) bad_at = k;
      if (bad_at >= 0) chk(0, {tag, " frame byte"}, fb[f][bad_at], ex[bad_at]);
      else chk(1, tag, 0, 0);
    end
  endtask

  task automatic put_addr(input logic [31:0] a, input bit four);
    if (four) begin ex[exn] = a[31:24]; exn++; end
    ex[exn] = a[23:16]; ex[exn+1] = a[15:8]; ex[exn+2] = a[7:0]; exn += 3;
  endtask

  task automatic do_req(input logic [3:0] op, input logic [31:0] a, input logic [8:0] l,
                        output logic e, output bit immediate);
    nf = 0; rcnt = 0; wptr = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_len = l;
    @(negedge clk);
    req_valid = 0;
    immediate = done;
    while (!done) @(negedge clk);
    e = err;
    @(negedge clk);
    chk(!done, "R13 done single cycle", done, 0);
  endtask

  task automatic read_test(input logic [3:0] op, input logic [31:0] a, input logic [8:0] l,
                           input bit four, input string tag);
    logic e; bit imm; int badi;
    do_req(op, a, l, e, imm);
    chk(nf == 1 && !e, {tag, " one frame, no err"}, nf, 1);
    exn = 0;
    ex[0] = (op == 4'd1) ? 8'h13 : (op == 4'd2) ? 8'h0B : 8'h03; exn = 1;
    put_addr(a, four);
    if (op == 4'd2) begin ex[exn] = 8'h00; exn++; end
    for (int k = 0; k < int'(l); k++) begin ex[exn] = 8'h00; exn++; end
    check_frame(0, tag);
    badi = -1;
    for (int k = 0; k < int'(l); k++) if (badi < 0 && rbuf[k] != pat(a + 32'(k))) badi = k;
    chk(rcnt == int'(l), {tag, " byte count"}, rcnt, l);
    if (badi >= 0) chk(0, {tag, " data"}, rbuf[badi], pat(a + 32'(badi)));
    else chk(1, tag, 0, 0);
  endtask

  task automatic modify_test(input logic [3:0] op, input logic [31:0] a, input logic [8:0] l,
                             input bit four, input string tag);
    logic e; bit imm;
    for (int k = 0; k < 256; k++) wbuf[k] = 8'((k * 13) ^ int'(l) ^ int'(a[7:0]));
    do_req(op, a, l, e, imm);
    chk(nf == 3 && !e, {tag, " R3 R9 three frames"}, nf, 3);
    exn = 1; ex[0] = 8'h06;
    check_frame(0, {tag, " R3 write enable"});
    case (op)
      4'd3: ex[0] = 8'h02;
      4'd4: ex[0] = 8'h20;
      4'd5: ex[0] = 8'h52;
      4'd6: ex[0] = 8'hD8;
      default: ex[0] = 8'hC7;
    endcase
    exn = 1;
    if (op != 4'd7) put_addr(a, four);
    if (op == 4'd3) for (int k = 0; k < int'(l); k++) begin ex[exn] = wbuf[k]; exn++; end
    check_frame(1, {tag, " command"});
    exn = 5; ex[0] = 8'h05; for (int k = 1; k < 5; k++) ex[k] = 8'h00;
    check_frame(2, {tag, " R9 poll until bit0 clear"});
  endtask

  task automatic simple_test(input logic [3:0] op, input logic [7:0] code, input string tag);
    logic e; bit imm;
    do_req(op, 32'h0, 9'd0, e, imm);
    exn = 1; ex[0] = code;
    chk(nf == 1 && !e, {tag, " one frame"}, nf, 1);
    check_frame(0, tag);
  endtask

  task automatic refuse_test(input logic [3:0] op, input logic [31:0] a, input logic [8:0] l,
                             input string tag);
    logic e; bit imm;
    do_req(op, a, l, e, imm);
    chk(e && imm, {tag, " R10 done+err next cycle"}, {imm, e}, 2'b11);
    chk(nf == 0, {tag, " R10 bus untouched"}, nf, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic e; bit imm;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && !sclk && req_ready && !done && !addr4, "R1 reset state",
        {cs_n, sclk, req_ready, done, addr4}, 5'b10100);

    read_test(4'd0, 32'h00123456, 9'd5, 0, "R6 read 3-byte");
    do_req(4'd8, 32'h0, 9'd0, e, imm);
    exn = 2; ex[0] = 8'h05; ex[1] = 8'h00;
    check_frame(0, "R12 status frame");
    chk(rcnt == 1 && rbuf[0] == 8'hA4, "R12 status byte", rbuf[0], 8'hA4);
    read_test(4'd2, 32'h00ABCDEF, 9'd4, 0, "R7 fast read dummy");
    read_test(4'd1, 32'h02345678, 9'd3, 1, "R6 read4 in 3-byte mode");
    modify_test(4'd4, 32'h00011000, 9'd0, 0, "R5 sector erase");
    modify_test(4'd5, 32'h00028000, 9'd0, 0, "R5 32K erase");
    modify_test(4'd6, 32'h00030000, 9'd0, 0, "R5 64K erase");
    modify_test(4'd7, 32'h00000000, 9'd0, 0, "R5 chip erase");
    simple_test(4'd9, 8'hB7, "R8 enter 4-byte");
    chk(addr4 == 1'b1, "R8 addr4 set", addr4, 1);
    read_test(4'd0, 32'h01234567, 9'd3, 1, "R8 read 4-byte");
    read_test(4'd2, 32'h01FFFFFE, 9'd2, 1, "R8 fast 4-byte");
    modify_test(4'd4, 32'h01FFF000, 9'd0, 1, "R8 sector 4-byte");
    modify_test(4'd3, 32'h01000020, 9'd8, 1, "R4 R8 program 4-byte");
    simple_test(4'd10, 8'hE9, "R8 exit 4-byte");
    chk(addr4 == 1'b0, "R8 addr4 clear", addr4, 0);
    refuse_test(4'd12, 32'h0, 9'd1, "R10 bad op");
    refuse_test(4'd0, 32'h0, 9'd0, "R10 read len 0");
    refuse_test(4'd3, 32'h0, 9'd257, "R10 program len 257");

    begin : sweep
      int offs [5] = '{0, 1, 128, 240, 255};
      int lens [7] = '{1, 2, 16, 17, 128, 255, 256};
      foreach (offs[i]) foreach (lens[j]) begin
        if (offs[i] + lens[j] > 256)
          refuse_test(4'd3, 32'h00004A00 + 32'(offs[i]), 9'(lens[j]), "R10 page cross");
        else
          modify_test(4'd3, 32'h00004A00 + 32'(offs[i]), 9'(lens[j]), 0, "R4 program sweep");
      end
    end

    chk(min_gap >= 2, "R11 cs high gap", min_gap, 2);
    chk(idle_clk == 0, "R2 sclk low while deselected", idle_clk, 0);
    chk(!err && req_ready, "R13 no err after carried-out request", err, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule